// File: doc/BRIEF.md
# Trim Parity Fault Latch with Self-Test Status

This block watches a parallel bank of stored trim bits. It raises a sticky fault when the bits hold an odd number of ones. It drives a status line that reports the fault ORed with the self-test request. The self-test request comes from an asynchronous pin. The block synchronizes it, passes it on as an enable for the sensing front end, and uses its rising edge as the only way to clear the fault. A clear takes effect only when the trim bits hold even parity again at that moment. The status line means nothing until the first self-test rising edge after power-up, so a separate flag marks when it becomes valid.

A four-state machine holds both the fault and the validity information:

- `PTL_BOOT_OK`: no edge seen yet, no fault.
- `PTL_BOOT_FAULT`: no edge seen yet, fault latched.
- `PTL_RUN_OK`: valid, no fault.
- `PTL_RUN_FAULT`: valid, fault latched.

The transitions are:

- **set**: odd parity moves either OK state to its FAULT twin.
- **arm**: a rising edge moves either BOOT state to RUN_FAULT if parity is odd, otherwise to RUN_OK.
- **clear**: a rising edge with even parity moves RUN_FAULT to RUN_OK.
- **hold**: in every other case the state stays where it is.

Top module: `ptl_status_monitor`

## Requirements
- R1: Parity is the XOR of all TRIM_W trim bits. A bit's position has no effect. An odd count of ones is a fault condition. An even count, including all zeros, is not.
- R2: Odd parity present before a rising clock edge sets the fault latch at that edge. The latch stays set after parity returns to even, until it is cleared by R4.
- R3: A synchronized self-test rising edge that meets odd parity leaves the latch set. This includes the cycle in which the fault first appears.
- R4: A synchronized self-test rising edge that meets even parity clears the latch.
- R5: status_o is registered. At each clock edge it takes the next latch value ORed with the synchronized self-test level seen before that edge. It is therefore high whenever self-test is high.
- R6: status_valid_o is low from reset until the first synchronized self-test rising edge. It is high from then on.
- R7: selftest_en_o follows selftest_pin through two clock flops. A high level driven before edge k appears after edge k+1.
- R8: While rst_n is low, status_o, status_valid_o and selftest_en_o are 0 and the latch is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| selftest_pin | input | 1 | Asynchronous self-test request, active high |
| trim_bits | input | TRIM_W | Stored trim bit vector |
| status_o | output | 1 | Fault latch ORed with self-test, registered |
| selftest_en_o | output | 1 | Synchronized self-test enable to the front end |
| status_valid_o | output | 1 | High once status_o is meaningful |

## Verification
The hardest case to reach is a self-test rising edge that lands in the same cycle as a fresh parity fault, and another that lands while an older fault is still present. Both depend on where the edge emerges from the two-flop synchronizer. The stimulus flips a trim bit in the exact cycle in which the pin's synchronized edge is due, which is two clock edges after the pin rises. A per-clock reference model then confirms that the latch stays set. A later edge with the parity restored must clear it.

// File: rtl/ptl_pkg.sv
package ptl_pkg;
    typedef enum logic [1:0] {
        PTL_BOOT_OK    = 2'd0,
        PTL_BOOT_FAULT = 2'd1,
        PTL_RUN_OK     = 2'd2,
        PTL_RUN_FAULT  = 2'd3
    } ptl_state_e;
endpackage

// File: rtl/ptl_sync_edge.sv
module ptl_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic level_o,
    output logic rise_o
);
    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            prev_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign level_o = chain_q[STAGES-1];
    assign rise_o  = chain_q[STAGES-1] & ~prev_q;

    // A rising edge lasts exactly one cycle
    assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |=> !rise_o);
endmodule

// File: rtl/ptl_parity.sv
module ptl_parity #(
    parameter int TRIM_W = 16
) (
    input  logic [TRIM_W-1:0] bits_i,
    output logic              odd_o
);
    logic [TRIM_W:0] acc;
    assign acc[0] = 1'b0;
    for (genvar i = 0; i < TRIM_W; i++) begin : g_xor
        assign acc[i+1] = acc[i] ^ bits_i[i];
    end
    assign odd_o = acc[TRIM_W];
endmodule

// File: rtl/ptl_fault_fsm.sv
module ptl_fault_fsm
    import ptl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic odd_i,
    input  logic rise_i,
    output logic fault_o,
    output logic fault_nxt_o,
    output logic valid_o
);
    ptl_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PTL_BOOT_OK;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PTL_BOOT_OK: begin
                if (rise_i)     state_d = odd_i ? PTL_RUN_FAULT : PTL_RUN_OK;
                else if (odd_i) state_d = PTL_BOOT_FAULT;
            end
            PTL_BOOT_FAULT: begin
                if (rise_i)     state_d = odd_i ? PTL_RUN_FAULT : PTL_RUN_OK;
            end
            PTL_RUN_OK: begin
                if (odd_i)      state_d = PTL_RUN_FAULT;
            end
            PTL_RUN_FAULT: begin
                if (rise_i && !odd_i) state_d = PTL_RUN_OK;
            end
            default:            state_d = PTL_BOOT_OK;
        endcase
    end

    always_comb begin
        fault_o     = (state_q == PTL_BOOT_FAULT) || (state_q == PTL_RUN_FAULT);
        fault_nxt_o = (state_d == PTL_BOOT_FAULT) || (state_d == PTL_RUN_FAULT);
        valid_o     = (state_q == PTL_RUN_OK)     || (state_q == PTL_RUN_FAULT);
    end

    assert_odd_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        odd_i |=> fault_o);
    assert_hold_until_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && !rise_i) |=> fault_o);
    assert_clear_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && odd_i) |=> fault_o);
    assert_clear_works_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i && !odd_i) |=> !fault_o);
    assert_valid_on_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise_i |=> valid_o);
    assert_valid_sticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> valid_o);
    assert_valid_needs_edge_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !rise_i) |=> !valid_o);
endmodule

// File: rtl/ptl_status_monitor.sv
module ptl_status_monitor #(
    parameter int TRIM_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              selftest_pin,
    input  logic [TRIM_W-1:0] trim_bits,
    output logic              status_o,
    output logic              selftest_en_o,
    output logic              status_valid_o
);
    logic st_level, st_rise, par_odd, fault, fault_nxt, valid;
    logic status_q;

    ptl_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(selftest_pin),
        .level_o(st_level), .rise_o(st_rise)
    );

    ptl_parity #(.TRIM_W(TRIM_W)) u_par (
        .bits_i(trim_bits), .odd_o(par_odd)
    );

    ptl_fault_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .odd_i(par_odd), .rise_i(st_rise),
        .fault_o(fault), .fault_nxt_o(fault_nxt), .valid_o(valid)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) status_q <= 1'b0;
        else        status_q <= fault_nxt | st_level;
    end

    assign status_o       = status_q;
    assign selftest_en_o  = st_level;
    assign status_valid_o = valid;

    assert_status_follows_st_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_level |=> status_o);
    assert_status_tracks_fault_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !st_level |=> (status_o == fault));
    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |-> (!status_o && !status_valid_o && !selftest_en_o));
endmodule

// File: tb/ptl_status_monitor_bench.sv
module ptl_status_monitor_bench;
    localparam int W = 16;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pin = 1'b0;
    logic [W-1:0] trim = '0;
    logic status, st_en, valid;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // model state
    bit m_s1, m_s2, m_prev, m_fault, m_valid, m_status;

    always #4 clk = ~clk;

    ptl_status_monitor #(.TRIM_W(W)) u_ptl_status_monitor (
        .clk(clk), .rst_n(rst_n), .selftest_pin(pin), .trim_bits(trim),
        .status_o(status), .selftest_en_o(st_en), .status_valid_o(valid)
    );

    function automatic bit odd_of(input logic [W-1:0] v);
        int n = 0;
        for (int i = 0; i < W; i++) if (v[i]) n++;
        return (n % 2) == 1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_fault = 0; m_valid = 0; m_status = 0;
        end else begin
            bit rise, od, fn;
            rise = m_s2 && !m_prev;
            od   = odd_of(trim);
            fn   = od || (m_fault && !rise);
            m_valid  = m_valid || rise;
            m_status = fn || m_s2;
            m_fault  = fn;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
        end
    end

    task automatic check(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) if (rst_n && !done) begin
        check("R5 status per-clock", status, m_status);
        check("R6 valid per-clock", valid, m_valid);
        check("R7 selftest_en per-clock", st_en, m_s2);
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cyc(2);
        check("R8 reset status", status, 1'b0);
        check("R8 reset valid", valid, 1'b0);
        check("R8 reset en", st_en, 1'b0);
        rst_n = 1'b1;
        cyc(3);
        // R1: even patterns incl. all-zero give no fault
        trim = 16'h0003; cyc(2);
        check("R1 even parity no fault", status, 1'b0);
        trim = 16'hFFFF; cyc(2);
        check("R1 all-ones even no fault", status, 1'b0);
        check("R6 valid low before edge", valid, 1'b0);
        // R2: single bit flip -> odd; fault latched even before valid
        trim = 16'hFFFE; cyc(1);
        check("R2 single flip sets fault", status, 1'b1);
        trim = 16'h0000; cyc(3);
        check("R2 latch holds after parity restored", status, 1'b1);
        check("R6 valid still low", valid, 1'b0);
        // R4: clear with even parity; also first edge makes valid
        pin = 1'b1; cyc(4);
        check("R7 en follows pin", st_en, 1'b1);
        check("R6 valid after first edge", valid, 1'b1);
        check("R5 status high with self-test", status, 1'b1);
        pin = 1'b0; cyc(4);
        check("R4 cleared after restored parity", status, 1'b0);
        // R5: status follows self-test with no fault
        pin = 1'b1; cyc(3);
        check("R5 status follows self-test high", status, 1'b1);
        pin = 1'b0; cyc(3);
        check("R5 status follows self-test low", status, 1'b0);
        // R3: clear attempt while fault persists
        trim = 16'h8000; cyc(2);
        pin = 1'b1; cyc(4); pin = 1'b0; cyc(4);
        check("R3 clear blocked while odd", status, 1'b1);
        trim = 16'h0000; cyc(2);
        check("R3 still latched", status, 1'b1);
        pin = 1'b1; cyc(4); pin = 1'b0; cyc(4);
        check("R4 clear succeeds", status, 1'b0);
        // R3: fault appears in the same cycle the edge emerges
        pin = 1'b1; cyc(1);   // pin seen at next edge k; rise active between k+1 and k+2
        cyc(1);
        trim = 16'h0100;      // odd before edge k+2, same cycle as rise
        cyc(1);
        trim = 16'h0000;
        pin = 1'b0; cyc(4);
        check("R3 same-cycle fault wins", status, 1'b1);
        pin = 1'b1; cyc(4); pin = 1'b0; cyc(4);
        check("R4 final clear", status, 1'b0);
        // R8: reset mid-run clears everything
        trim = 16'h0001; cyc(2);
        rst_n = 1'b0; #2;
        check("R8 async reset status", status, 1'b0);
        check("R8 async reset valid", valid, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule